// File: doc/BRIEF.md
# Edge Counter Timer Register File

This block is the register file that software uses to steer an external edge counter. A single-cycle bus port writes control, configuration, period-limit and match values. The same port reads them back together with the live count and a pair of write-complete flags. Its outputs drive the counter directly: enable, free-run request, counting style (quadrature or single-input pulse), edge polarity, the period limit and the match value.

The period-limit and match registers behave like values that cross into a slower counting domain. They are accepted only while the timer is enabled. Each accepted value reaches its output a fixed number of cycles after the write, and a sticky status flag rises on that same edge. Software drops a flag by writing a one to the matching bit of the clear register. The configuration register is locked while the timer is enabled.

Top module: `tmr_regif`

## Requirements
- R1: After reset, the control register reads 0, the configuration register reads 0, the period limit reads 0xFFFF, the match value reads 0 and both status flags read 0.
- R2: A write to address 2 (period limit) or address 3 (match) while enabled changes the read-back value and the matching output exactly SYNC_DLY clock edges after the write edge. The matching status flag rises on that same edge. A transfer that has started completes even if the timer is disabled meanwhile.
- R3: Writes to address 2 or 3 while the enable bit is clear change neither the value nor any status flag.
- R4: Writing address 6 clears status bit 0 (period-limit done) where data bit 0 is 1, and status bit 1 (match done) where data bit 1 is 1. Zero bits leave a flag as it is. When a transfer completes on the same edge as its clear, the flag ends up set.
- R5: Control register at address 0: bit 0 is enable and bit 1 is free-run. Free-run is held only when written together with enable, and runOut is high exactly while both are held.
- R6: Writing 0 to the control register clears both enable and free-run, and runOut falls after that edge.
- R7: Configuration register at address 1: bit 0 is quadrature mode, bit 1 is pulse mode, and bits 3:2 are polarity (0 rising, 1 falling, 2 both). It takes writes only while enable is clear; writes while enabled are ignored.
- R8: countOn is high when runOut is high and at least one of quadrature mode or pulse mode is set. With both clear, external counting stays off.
- R9: Address 4 reads the countIn input. Writes to it change no register.
- R10: Address 5 reads the status flags in bits 1:0. Address 6 and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Register word address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational from busAddr |
| countIn | input | CNT_W | Live count from the counter |
| enableOut | output | 1 | Timer enable |
| runOut | output | 1 | Free-running count request |
| encModeOut | output | 1 | Quadrature mode |
| pulseModeOut | output | 1 | Single-input pulse mode |
| polarityOut | output | 2 | Active edge selection |
| countOn | output | 1 | External counting active |
| ceilingOut | output | CNT_W | Committed period limit |
| compareOut | output | CNT_W | Committed match value |

## Verification
The clear register and the end of a delayed transfer can act on the same status flag in the same cycle. The bench provokes this by timing a clear of the period-limit flag to land on the very edge where that transfer completes. It then checks that the flag reads 1 afterwards, and that a second clear drops it. The remaining behaviour is covered by directed cases and a seeded random sequence of control, configuration, load, clear and count-register writes. After every step, all readable registers and outputs are compared with a reference model in the bench.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  parameter int ADDR_W = 3;
  parameter int NCH    = 2;
  parameter int CH_CEIL = 0;
  parameter int CH_CMP  = 1;

  parameter logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  parameter logic [ADDR_W-1:0] ADR_CFG   = 3'd1;
  parameter logic [ADDR_W-1:0] ADR_CEIL  = 3'd2;
  parameter logic [ADDR_W-1:0] ADR_CMP   = 3'd3;
  parameter logic [ADDR_W-1:0] ADR_COUNT = 3'd4;
  parameter logic [ADDR_W-1:0] ADR_STAT  = 3'd5;
  parameter logic [ADDR_W-1:0] ADR_CLR   = 3'd6;

  typedef struct packed {
    logic           ctrlWr;
    logic           cfgWr;
    logic [NCH-1:0] loadWr;
    logic [NCH-1:0] okClr;
  } strobe_t;
endpackage

// File: rtl/tmr_regif_sync.sv
module tmr_regif_sync #(
  parameter int W = 16,
  parameter int DLY = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] ldData,
  input  logic         clrOk,
  output logic [W-1:0] valOut,
  output logic         okOut
);
  logic [DLY-1:0] pipe;
  logic [W-1:0]   pend;
  logic           commit;

  assign commit = pipe[DLY-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe   <= '0;
      pend   <= '0;
      valOut <= RST_VAL;
      okOut  <= 1'b0;
    end else begin
      pipe <= (pipe << 1) | DLY'(load);
      if (load) pend <= ldData;
      if (commit) valOut <= pend;
      // completion wins over a clear on the same edge
      if (commit) okOut <= 1'b1;
      else if (clrOk) okOut <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_regif_ctrl.sv
module tmr_regif_ctrl
  import tmr_regif_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              enState,
  output strobe_t           strb
);
  logic wrAny;
  assign wrAny = busSel & busWe;

  always_comb begin
    strb = '0;
    if (wrAny) begin
      unique case (busAddr)
        ADR_CTRL: strb.ctrlWr = 1'b1;
        ADR_CFG:  strb.cfgWr  = ~enState;
        ADR_CEIL: strb.loadWr[CH_CEIL] = enState;
        ADR_CMP:  strb.loadWr[CH_CMP]  = enState;
        ADR_CLR:  strb.okClr = busWdata[NCH-1:0];
        default:  strb = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_regif_dp.sv
module tmr_regif_dp
  import tmr_regif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int SYNC_DLY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  countIn,
  output logic [DATA_W-1:0] busRdata,
  output logic              enableR,
  output logic              contR,
  output logic              encR,
  output logic              pulseR,
  output logic [1:0]        polR,
  output logic [CNT_W-1:0]  chVal [NCH],
  output logic [NCH-1:0]    okFlags
);
  localparam logic [CNT_W-1:0] CEIL_RST = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableR <= 1'b0;
      contR   <= 1'b0;
      encR    <= 1'b0;
      pulseR  <= 1'b0;
      polR    <= 2'b00;
    end else begin
      if (strb.ctrlWr) begin
        enableR <= busWdata[0];
        contR   <= busWdata[0] & busWdata[1];
      end
      if (strb.cfgWr) begin
        encR   <= busWdata[0];
        pulseR <= busWdata[1];
        polR   <= busWdata[3:2];
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_regif_sync #(
      .W(CNT_W), .DLY(SYNC_DLY),
      .RST_VAL((c == CH_CEIL) ? CEIL_RST : '0)
    ) sync_i (
      .clk(clk), .rstN(rstN),
      .load(strb.loadWr[c]),
      .ldData(busWdata[CNT_W-1:0]),
      .clrOk(strb.okClr[c]),
      .valOut(chVal[c]),
      .okOut(okFlags[c])
    );
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADR_CTRL:  busRdata = DATA_W'({contR, enableR});
      ADR_CFG:   busRdata = DATA_W'({polR, pulseR, encR});
      ADR_CEIL:  busRdata = DATA_W'(chVal[CH_CEIL]);
      ADR_CMP:   busRdata = DATA_W'(chVal[CH_CMP]);
      ADR_COUNT: busRdata = DATA_W'(countIn);
      ADR_STAT:  busRdata = DATA_W'(okFlags);
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  parameter int SYNC_DLY = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  countIn,
  output logic              enableOut,
  output logic              runOut,
  output logic              encModeOut,
  output logic              pulseModeOut,
  output logic [1:0]        polarityOut,
  output logic              countOn,
  output logic [CNT_W-1:0]  ceilingOut,
  output logic [CNT_W-1:0]  compareOut
);
  strobe_t          strb;
  logic             contR;
  logic [CNT_W-1:0] chVal [NCH];
  logic [NCH-1:0]   okFlags;

  tmr_regif_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .enState(enableOut), .strb(strb)
  );

  tmr_regif_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_DLY(SYNC_DLY)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busAddr(busAddr), .countIn(countIn), .busRdata(busRdata),
    .enableR(enableOut), .contR(contR), .encR(encModeOut),
    .pulseR(pulseModeOut), .polR(polarityOut), .chVal(chVal),
    .okFlags(okFlags)
  );

  assign runOut     = enableOut & contR;
  assign countOn    = runOut & (encModeOut | pulseModeOut);
  assign ceilingOut = chVal[CH_CEIL];
  assign compareOut = chVal[CH_CMP];
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk
  import tmr_regif_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              enableOut,
  input logic              runOut,
  input logic              encModeOut,
  input logic              pulseModeOut,
  input logic [1:0]        polarityOut,
  input logic [CNT_W-1:0]  ceilingOut,
  input logic [CNT_W-1:0]  compareOut,
  input logic [NCH-1:0]    okFlags
);
  logic wrCtrl, wrCfg, wrClr;
  assign wrCtrl = busSel & busWe & (busAddr == ADR_CTRL);
  assign wrCfg  = busSel & busWe & (busAddr == ADR_CFG);
  assign wrClr  = busSel & busWe & (busAddr == ADR_CLR);

  p_ceil_load_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ceilingOut) |-> okFlags[CH_CEIL]);
  p_cmp_load_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(compareOut) |-> okFlags[CH_CMP]);
  p_ceil_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(okFlags[CH_CEIL]) |-> $past(wrClr && busWdata[0]));
  p_cmp_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(okFlags[CH_CMP]) |-> $past(wrClr && busWdata[1]));
  p_run_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runOut) |-> $past(wrCtrl && busWdata[1:0] == 2'b11));
  p_stop_on_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWdata[1:0] == 2'b00) |=> (!runOut && !enableOut));
  p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enableOut && wrCfg) |=> $stable({encModeOut, pulseModeOut, polarityOut}));
endmodule

bind tmr_regif tmr_regif_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/tmr_regif_tb_top.sv
module tmr_regif_tb_top;
  localparam int DATA_W = 32;
  localparam int CNT_W = 16;
  localparam int SYNC_DLY = 3;

  logic clk = 1'b0;
  logic rstN;
  logic busSel, busWe;
  logic [2:0] busAddr;
  logic [DATA_W-1:0] busWdata, busRdata;
  logic [CNT_W-1:0] countIn;
  logic enableOut, runOut, encModeOut, pulseModeOut, countOn;
  logic [1:0] polarityOut;
  logic [CNT_W-1:0] ceilingOut, compareOut;

  int checks = 0;
  int errors = 0;

  // model
  logic mEn, mCs, mEnc, mPulse;
  logic [1:0] mPol, mOk;
  logic [CNT_W-1:0] mCeil, mCmp;

  always #4 clk = ~clk;

  tmr_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_DLY(SYNC_DLY)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .countIn(countIn), .enableOut(enableOut), .runOut(runOut),
    .encModeOut(encModeOut), .pulseModeOut(pulseModeOut),
    .polarityOut(polarityOut), .countOn(countOn),
    .ceilingOut(ceilingOut), .compareOut(compareOut)
  );

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {30'd0, mCs, mEn};
      3'd1: return {28'd0, mPol, mPulse, mEnc};
      3'd2: return {16'd0, mCeil};
      3'd3: return {16'd0, mCmp};
      3'd4: return {16'd0, countIn};
      3'd5: return {30'd0, mOk};
      default: return 32'd0;
    endcase
  endfunction

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    case (a)
      3'd0: begin mEn = d[0]; mCs = d[0] & d[1]; end
      3'd1: if (!mEn) begin mEnc = d[0]; mPulse = d[1]; mPol = d[3:2]; end
      3'd2: if (mEn) begin mCeil = d[15:0]; mOk[0] = 1'b1; end
      3'd3: if (mEn) begin mCmp = d[15:0]; mOk[1] = 1'b1; end
      3'd6: mOk = mOk & ~d[1:0];
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check($sformatf("%s R10 read addr %0d", tag, a), d, expRead(3'(a)));
    end
    check({tag, " R5 runOut"}, {31'd0, runOut}, {31'd0, mEn & mCs});
    check({tag, " R8 countOn"}, {31'd0, countOn}, {31'd0, mEn & mCs & (mEnc | mPulse)});
    check({tag, " R7 cfg outputs"}, {28'd0, polarityOut, pulseModeOut, encModeOut},
          {28'd0, mPol, mPulse, mEnc});
    check({tag, " R2 ceilingOut"}, {16'd0, ceilingOut}, {16'd0, mCeil});
    check({tag, " R2 compareOut"}, {16'd0, compareOut}, {16'd0, mCmp});
  endtask

  task automatic waitDly();
    repeat (SYNC_DLY) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] oldV;
    void'($urandom(32'd20240611));
    rstN = 1'b0; busSel = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0;
    countIn = 16'h1357;
    mEn = 0; mCs = 0; mEnc = 0; mPulse = 0; mPol = 0; mOk = 0;
    mCeil = 16'hFFFF; mCmp = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkAll("R1 reset");

    // R3 loads ignored while disabled
    wr(3'd2, 32'h1234); wr(3'd3, 32'h4321); waitDly();
    checkAll("R3 disabled load");

    // R7 config while disabled
    wr(3'd1, 32'hD);
    checkAll("R7 cfg write");

    // R5 free-run needs enable
    wr(3'd0, 32'h2); checkAll("R5 cs alone");
    wr(3'd0, 32'h1); checkAll("R5 enable only");
    wr(3'd0, 32'h3); checkAll("R5 R8 running");

    // R7 config locked while enabled
    wr(3'd1, 32'h2); checkAll("R7 cfg locked");

    // R2 exact delay of period-limit load
    oldV = ceilingOut;
    wr(3'd2, 32'h00AB);
    for (int i = 0; i < SYNC_DLY - 1; i++) begin
      rd(3'd2, d); check("R2 ceil not yet", d, {16'd0, oldV});
      rd(3'd5, d); check("R2 flag not yet", d, 32'd0);
      @(negedge clk);
    end
    rd(3'd2, d); check("R2 ceil before commit edge", d, {16'd0, oldV});
    @(negedge clk);
    rd(3'd2, d); check("R2 ceil committed", d, 32'h00AB);
    rd(3'd5, d); check("R2 ceil flag", d, 32'd1);

    wr(3'd3, 32'h0055);
    repeat (SYNC_DLY - 1) @(negedge clk);
    rd(3'd3, d); check("R2 cmp not yet", d, 32'd0);
    @(negedge clk);
    rd(3'd3, d); check("R2 cmp committed", d, 32'h0055);
    checkAll("R2 both loaded");

    // R4 clear masks
    wr(3'd6, 32'h0); checkAll("R4 zero mask");
    wr(3'd6, 32'h1); checkAll("R4 clear ceil flag");
    wr(3'd6, 32'h2); checkAll("R4 clear cmp flag");

    // R4 completion on the same edge as its clear
    wr(3'd2, 32'h0777);
    repeat (SYNC_DLY - 1) @(negedge clk);
    wr(3'd6, 32'h1);
    rd(3'd5, d); check("R4 set wins over clear", d, 32'd1);
    mOk[0] = 1'b1;
    wr(3'd6, 32'h1);
    checkAll("R4 second clear");

    // R9 count register
    countIn = 16'h5A5A;
    wr(3'd4, 32'h0);
    checkAll("R9 count write ignored");

    // R2 transfer finishes after disable; R6 zero write stops
    wr(3'd2, 32'h0999);
    wr(3'd0, 32'h0);
    waitDly();
    checkAll("R2 R6 disable mid-transfer");
    wr(3'd6, 32'h3);

    // R8 zero mode fields keep counting off
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h3);
    checkAll("R8 modes zero");

    // random phase
    for (int it = 0; it < 400; it++) begin
      logic [31:0] r;
      r = $urandom;
      countIn = r[31:16];
      case ($urandom_range(0, 5))
        0: wr(3'd0, {30'd0, r[1:0]});
        1: wr(3'd1, {28'd0, r[3:0]});
        2: begin wr(3'd2, r); waitDly(); end
        3: begin wr(3'd3, r); waitDly(); end
        4: wr(3'd4, r);
        default: wr(3'd6, {30'd0, r[1:0]});
      endcase
      checkAll("rand R2 R3 R4 R5 R7 R9");
    end

    finishRun();
  end
endmodule